// File: doc/BRIEF.md
# Programmable YCbCr-to-RGB Matrix Converter

This block sits in a display pixel path and turns one 10-bit pixel per clock from YCbCr into RGB. A 3x3 matrix of signed fixed-point coefficients is applied to each YCbCr pixel. The matrix comes from one of two built-in full-range presets (BT.601 or BT.709) or from nine programmable coefficients. Pixels flagged as RGB skip the matrix and come out unchanged. Chroma arrives already signed and at full range. Before the multiply, each input component gets a programmable offset and is then clamped to its legal range. After rounding, each output component gets a programmable offset and is saturated to 10 bits.

Configuration is written over a simple write port into a shadow bank. The shadow bank is copied into the active bank only on a frame-start pulse, so a frame is never converted with a mix of old and new settings. The datapath has three register stages and a fixed latency. The valid and bypass flags travel alongside the data.

Top module: `ycc_rgb_matrix`

## Requirements
- R1: For a YCbCr pixel, each output is a dot product over the input vector ordered (Cr, Y, Cb). R uses c0,c1,c2, G uses c3,c4,c5 and B uses c6,c7,c8. Coefficients are signed s3.12, where 4096 means 1.0. The sum is kept at full precision, 2048 is added, and the result is arithmetically shifted right by 12. After the output offset is added, the result is saturated to 0..1023.
- R2: After reset, out_valid and all outputs are 0, every offset is 0 and the BT.601 preset is active.
- R3: Register 0 holds control. Bit 1 set selects the programmed coefficients. With bit 1 clear, bit 0 picks the preset: 0 gives BT.601 with rows (5743,4096,0), (-2925,4096,-1410), (0,4096,7258); 1 gives BT.709 with rows (6450,4096,0), (-1917,4096,-767), (0,4096,7601).
- R4: Registers 1 to 4 each hold a coefficient pair. Register k holds c(2k-2) in bits [15:0] and c(2k-1) in bits [31:16]. Register 5 holds c8 in bits [15:0].
- R5: Registers 6, 7 and 8 serve channels 0, 1 and 2. Bits [10:0] hold a signed input offset, added to input column Cr, Y or Cb respectively. Bits [26:16] hold a signed output offset, added after rounding to R, G or B respectively.
- R6: After its input offset is added, Y is clamped to 0..1023 and Cr and Cb are clamped to -512..512, before the multiply.
- R7: A pixel with in_is_yuv=0 bypasses the matrix, the offsets and the clamps. Then out_r = in_c0[9:0], out_g = in_c1 and out_b = in_c2[9:0].
- R8: A pixel sampled at clock edge k appears on the outputs after edge k+2. out_valid repeats in_valid with the same delay and is 0 otherwise.
- R9: Writes update only the shadow bank. The active bank takes the shadow contents at an edge where frame_start is 1, and a write in that same edge is not included. Writes to addresses 9..15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Copies the shadow bank into the active bank |
| in_valid | input | 1 | Input pixel valid |
| in_is_yuv | input | 1 | 1 = YCbCr pixel, 0 = RGB pixel (bypass) |
| in_c0 | input | 11 | Cr (signed) or R (bits 9:0) |
| in_c1 | input | 10 | Y or G |
| in_c2 | input | 11 | Cb (signed) or B (bits 9:0) |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 10 | Red |
| out_g | output | 10 | Green |
| out_b | output | 10 | Blue |

## Verification
The hardest state to reach is a pixel that hits an input clamp and output saturation together, under a newly committed programmed matrix, while the shadow bank already holds different values. The stimulus first writes settings without a frame-start pulse and checks that the old matrix still applies. It then commits. It then programs input offsets large enough to push Y above 1023 and Cb below -512, so the clamps, rounding and saturation all act in the same pixels. RGB pixels are interleaved between YCbCr pixels, and gaps in the valid stream test that the flags stay aligned with the data.

// File: rtl/ycc_pkg.sv
package ycc_pkg;

    localparam int NUM_CH     = 3;
    localparam int NUM_COEF   = 9;
    localparam int LUMA_CH    = 1;

    localparam int REG_CTRL   = 0;
    localparam int REG_PAIR0  = 1;
    localparam int NUM_PAIRS  = 4;
    localparam int REG_LAST   = 5;
    localparam int REG_OFF0   = 6;

    localparam int CTRL_BT709 = 0;
    localparam int CTRL_PROG  = 1;

    // built-in full-range matrices, s3.12, row-major over (Cr, Y, Cb)
    function automatic logic signed [15:0] preset_coef(input logic use709, input int idx);
        logic signed [15:0] c;
        case (idx)
            0:       c = use709 ? 16'sd6450  : 16'sd5743;
            1:       c = 16'sd4096;
            2:       c = 16'sd0;
            3:       c = use709 ? -16'sd1917 : -16'sd2925;
            4:       c = 16'sd4096;
            5:       c = use709 ? -16'sd767  : -16'sd1410;
            6:       c = 16'sd0;
            7:       c = 16'sd4096;
            8:       c = use709 ? 16'sd7601  : 16'sd7258;
            default: c = 16'sd0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ycc_cfg_regs.sv
module ycc_cfg_regs
    import ycc_pkg::*;
#(
    parameter int COEF_W = 16,
    parameter int CH_W   = 11,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic [ADDR_W-1:0]                  cfg_addr,
    input  logic [DATA_W-1:0]                  cfg_wdata,
    input  logic                               frame_start,
    output logic [NUM_COEF-1:0][COEF_W-1:0]    coef_o,
    output logic [NUM_CH-1:0][CH_W-1:0]        ioff_o,
    output logic [NUM_CH-1:0][CH_W-1:0]        ooff_o
);

    localparam int OOFF_LSB = DATA_W / 2;

    typedef struct packed {
        logic [1:0]                         ctrl;
        logic [NUM_COEF-1:0][COEF_W-1:0]    coef;
        logic [NUM_CH-1:0][CH_W-1:0]        ioff;
        logic [NUM_CH-1:0][CH_W-1:0]        ooff;
    } bank_t;

    typedef struct packed {
        bank_t sh;
        bank_t act;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (frame_start) begin
            r_d.act = r_q.sh;
        end
        if (cfg_we) begin
            if (cfg_addr == ADDR_W'(REG_CTRL)) begin
                r_d.sh.ctrl = cfg_wdata[1:0];
            end
            for (int k = 0; k < NUM_PAIRS; k++) begin
                if (cfg_addr == ADDR_W'(REG_PAIR0 + k)) begin
                    r_d.sh.coef[2*k]   = cfg_wdata[COEF_W-1:0];
                    r_d.sh.coef[2*k+1] = cfg_wdata[OOFF_LSB +: COEF_W];
                end
            end
            if (cfg_addr == ADDR_W'(REG_LAST)) begin
                r_d.sh.coef[NUM_COEF-1] = cfg_wdata[COEF_W-1:0];
            end
            for (int j = 0; j < NUM_CH; j++) begin
                if (cfg_addr == ADDR_W'(REG_OFF0 + j)) begin
                    r_d.sh.ioff[j] = cfg_wdata[CH_W-1:0];
                    r_d.sh.ooff[j] = cfg_wdata[OOFF_LSB +: CH_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    for (genvar i = 0; i < NUM_COEF; i++) begin : g_coef_sel
        assign coef_o[i] = r_q.act.ctrl[CTRL_PROG] ? r_q.act.coef[i]
                         : COEF_W'(preset_coef(r_q.act.ctrl[CTRL_BT709], i));
    end

    assign ioff_o = r_q.act.ioff;
    assign ooff_o = r_q.act.ooff;

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(r_q.act)) else $error("active bank changed without frame start"); // R9

endmodule

// File: rtl/ycc_in_stage.sv
module ycc_in_stage
    import ycc_pkg::*;
#(
    parameter int PIX_W = 10,
    parameter int CH_W  = 11
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic                          in_yuv,
    input  logic [NUM_CH-1:0][CH_W-1:0]   in_v,
    input  logic [NUM_CH-1:0][PIX_W-1:0]  in_raw,
    input  logic [NUM_CH-1:0][CH_W-1:0]   ioff,
    output logic                          out_valid,
    output logic                          out_yuv,
    output logic [NUM_CH-1:0][CH_W-1:0]   out_v,
    output logic [NUM_CH-1:0][PIX_W-1:0]  out_raw
);

    localparam int SUM_W     = CH_W + 1;
    localparam int LUMA_MAX  = (1 << PIX_W) - 1;
    localparam int CHROMA_LIM = 1 << (PIX_W - 1);

    typedef struct packed {
        logic                          valid;
        logic                          yuv;
        logic [NUM_CH-1:0][CH_W-1:0]   v;
        logic [NUM_CH-1:0][PIX_W-1:0]  raw;
    } s1_t;

    s1_t s_d, s_q;
    logic [NUM_CH-1:0][CH_W-1:0] clamp_w;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_clamp
        localparam int LO = (ch == LUMA_CH) ? 0 : -CHROMA_LIM;
        localparam int HI = (ch == LUMA_CH) ? LUMA_MAX : CHROMA_LIM;
        logic signed [SUM_W-1:0] sum;
        assign sum = SUM_W'($signed(in_v[ch])) + SUM_W'($signed(ioff[ch]));
        assign clamp_w[ch] = (sum < SUM_W'(LO)) ? CH_W'(LO)
                           : (sum > SUM_W'(HI)) ? CH_W'(HI)
                           : CH_W'(sum);
    end

    always_comb begin
        s_d       = s_q;
        s_d.valid = in_valid;
        s_d.yuv   = in_yuv;
        s_d.v     = clamp_w;
        s_d.raw   = in_raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.valid;
    assign out_yuv   = s_q.yuv;
    assign out_v     = s_q.v;
    assign out_raw   = s_q.raw;

    AST_LUMA_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.valid && s_q.yuv) |-> ($signed(s_q.v[LUMA_CH]) >= 0 &&
                                    $signed(s_q.v[LUMA_CH]) <= LUMA_MAX)) else $error("luma out of range"); // R6
    AST_CHROMA_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.valid && s_q.yuv) |-> ($signed(s_q.v[0]) >= -CHROMA_LIM && $signed(s_q.v[0]) <= CHROMA_LIM &&
                                    $signed(s_q.v[2]) >= -CHROMA_LIM && $signed(s_q.v[2]) <= CHROMA_LIM)) else $error("chroma out of range"); // R6

endmodule

// File: rtl/ycc_mul_stage.sv
module ycc_mul_stage
    import ycc_pkg::*;
#(
    parameter int PIX_W  = 10,
    parameter int CH_W   = 11,
    parameter int COEF_W = 16,
    localparam int PROD_W = CH_W + COEF_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic                            in_yuv,
    input  logic [NUM_CH-1:0][CH_W-1:0]     in_v,
    input  logic [NUM_CH-1:0][PIX_W-1:0]    in_raw,
    input  logic [NUM_COEF-1:0][COEF_W-1:0] coef,
    output logic                            out_valid,
    output logic                            out_yuv,
    output logic [NUM_COEF-1:0][PROD_W-1:0] out_p,
    output logic [NUM_CH-1:0][PIX_W-1:0]    out_raw
);

    typedef struct packed {
        logic                            valid;
        logic                            yuv;
        logic [NUM_COEF-1:0][PROD_W-1:0] p;
        logic [NUM_CH-1:0][PIX_W-1:0]    raw;
    } s2_t;

    s2_t s_d, s_q;
    logic [NUM_COEF-1:0][PROD_W-1:0] prod_w;

    for (genvar i = 0; i < NUM_COEF; i++) begin : g_mul
        localparam int COL = i % NUM_CH;
        logic signed [PROD_W-1:0] a, b;
        assign a = PROD_W'($signed(coef[i]));
        assign b = PROD_W'($signed(in_v[COL]));
        assign prod_w[i] = a * b;
    end

    always_comb begin
        s_d       = s_q;
        s_d.valid = in_valid;
        s_d.yuv   = in_yuv;
        s_d.p     = prod_w;
        s_d.raw   = in_raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.valid;
    assign out_yuv   = s_q.yuv;
    assign out_p     = s_q.p;
    assign out_raw   = s_q.raw;

endmodule

// File: rtl/ycc_sum_stage.sv
module ycc_sum_stage
    import ycc_pkg::*;
#(
    parameter int PIX_W  = 10,
    parameter int CH_W   = 11,
    parameter int COEF_W = 16,
    parameter int FRAC_W = 12,
    localparam int PROD_W = CH_W + COEF_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic                            in_yuv,
    input  logic [NUM_COEF-1:0][PROD_W-1:0] in_p,
    input  logic [NUM_CH-1:0][PIX_W-1:0]    in_raw,
    input  logic [NUM_CH-1:0][CH_W-1:0]     ooff,
    output logic                            out_valid,
    output logic [NUM_CH-1:0][PIX_W-1:0]    out_rgb
);

    localparam int ACC_W = PROD_W + 2;
    localparam int ROUND = 1 << (FRAC_W - 1);
    localparam int MAXV  = (1 << PIX_W) - 1;

    typedef struct packed {
        logic                         valid;
        logic [NUM_CH-1:0][PIX_W-1:0] rgb;
    } s3_t;

    s3_t s_d, s_q;
    logic [NUM_CH-1:0][PIX_W-1:0] pix_w;
    logic signed [ACC_W:0]        res_w [NUM_CH];

    for (genvar r = 0; r < NUM_CH; r++) begin : g_row
        logic signed [ACC_W-1:0] acc, rnd;
        logic [PIX_W-1:0]        sat;
        assign acc = ACC_W'($signed(in_p[3*r])) + ACC_W'($signed(in_p[3*r+1]))
                   + ACC_W'($signed(in_p[3*r+2]));
        assign rnd = (acc + ACC_W'(ROUND)) >>> FRAC_W;
        assign res_w[r] = (ACC_W+1)'(rnd) + (ACC_W+1)'($signed(ooff[r]));
        assign sat = (res_w[r] < 0) ? '0
                   : (res_w[r] > (ACC_W+1)'(MAXV)) ? PIX_W'(MAXV)
                   : PIX_W'(res_w[r]);
        assign pix_w[r] = in_yuv ? sat : in_raw[r];
    end

    always_comb begin
        s_d       = s_q;
        s_d.valid = in_valid;
        s_d.rgb   = pix_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.valid;
    assign out_rgb   = s_q.rgb;

    AST_SAT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_yuv && res_w[0] < 0) |=> (s_q.rgb[0] == '0)) else $error("negative red not floored"); // R1
    AST_SAT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_yuv && res_w[2] > MAXV) |=> (s_q.rgb[2] == PIX_W'(MAXV))) else $error("blue not saturated"); // R1

endmodule

// File: rtl/ycc_rgb_matrix.sv
module ycc_rgb_matrix
    import ycc_pkg::*;
#(
    parameter int PIX_W  = 10,
    parameter int COEF_W = 16,
    parameter int FRAC_W = 12,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    localparam int CH_W  = PIX_W + 1,
    localparam int PROD_W = CH_W + COEF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              frame_start,
    input  logic              in_valid,
    input  logic              in_is_yuv,
    input  logic [CH_W-1:0]   in_c0,
    input  logic [PIX_W-1:0]  in_c1,
    input  logic [CH_W-1:0]   in_c2,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_r,
    output logic [PIX_W-1:0]  out_g,
    output logic [PIX_W-1:0]  out_b
);

    logic [NUM_COEF-1:0][COEF_W-1:0] coef;
    logic [NUM_CH-1:0][CH_W-1:0]     ioff, ooff;
    logic [NUM_CH-1:0][CH_W-1:0]     in_v;
    logic [NUM_CH-1:0][PIX_W-1:0]    in_raw;

    logic                            s1_valid, s1_yuv;
    logic [NUM_CH-1:0][CH_W-1:0]     s1_v;
    logic [NUM_CH-1:0][PIX_W-1:0]    s1_raw;
    logic                            s2_valid, s2_yuv;
    logic [NUM_COEF-1:0][PROD_W-1:0] s2_p;
    logic [NUM_CH-1:0][PIX_W-1:0]    s2_raw;
    logic [NUM_CH-1:0][PIX_W-1:0]    rgb;

    assign in_v[0]   = in_c0;
    assign in_v[1]   = CH_W'(in_c1);
    assign in_v[2]   = in_c2;
    assign in_raw[0] = in_c0[PIX_W-1:0];
    assign in_raw[1] = in_c1;
    assign in_raw[2] = in_c2[PIX_W-1:0];

    ycc_cfg_regs #(.COEF_W(COEF_W), .CH_W(CH_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start),
        .coef_o(coef), .ioff_o(ioff), .ooff_o(ooff)
    );

    ycc_in_stage #(.PIX_W(PIX_W), .CH_W(CH_W)) u_in (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_yuv(in_is_yuv),
        .in_v(in_v), .in_raw(in_raw), .ioff(ioff),
        .out_valid(s1_valid), .out_yuv(s1_yuv), .out_v(s1_v), .out_raw(s1_raw)
    );

    ycc_mul_stage #(.PIX_W(PIX_W), .CH_W(CH_W), .COEF_W(COEF_W)) u_mul (
        .clk(clk), .rst_n(rst_n), .in_valid(s1_valid), .in_yuv(s1_yuv),
        .in_v(s1_v), .in_raw(s1_raw), .coef(coef),
        .out_valid(s2_valid), .out_yuv(s2_yuv), .out_p(s2_p), .out_raw(s2_raw)
    );

    ycc_sum_stage #(.PIX_W(PIX_W), .CH_W(CH_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_sum (
        .clk(clk), .rst_n(rst_n), .in_valid(s2_valid), .in_yuv(s2_yuv),
        .in_p(s2_p), .in_raw(s2_raw), .ooff(ooff),
        .out_valid(out_valid), .out_rgb(rgb)
    );

    assign out_r = rgb[0];
    assign out_g = rgb[1];
    assign out_b = rgb[2];

    // cycles since reset, so that three-deep history checks see only post-reset samples
    logic [1:0] warm_d, warm_q;
    assign warm_d = (warm_q == 2'd3) ? warm_q : warm_q + 2'd1;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm_q <= '0;
        else        warm_q <= warm_d;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (out_valid == $past(in_valid, 3))) else $error("valid misaligned"); // R8
    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3 && out_valid && !$past(in_is_yuv, 3)) |->
        (out_r == $past(in_c0[PIX_W-1:0], 3) && out_g == $past(in_c1, 3) &&
         out_b == $past(in_c2[PIX_W-1:0], 3))) else $error("bypass pixel altered"); // R7

endmodule

// File: tb/ycc_rgb_matrix_bench.sv
`timescale 1ns/1ps
module ycc_rgb_matrix_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        frame_start = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_is_yuv = 1'b0;
    logic [10:0] in_c0 = '0;
    logic [9:0]  in_c1 = '0;
    logic [10:0] in_c2 = '0;
    logic        out_valid;
    logic [9:0]  out_r, out_g, out_b;

    always #4 clk = ~clk;

    ycc_rgb_matrix u_ycc_rgb_matrix (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start), .in_valid(in_valid),
        .in_is_yuv(in_is_yuv), .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;
    string cur_tag = "R1";

    int p601[9] = '{5743, 4096, 0, -2925, 4096, -1410, 0, 4096, 7258};
    int p709[9] = '{6450, 4096, 0, -1917, 4096, -767, 0, 4096, 7601};

    int sh_ctrl, act_ctrl;
    int sh_coef[9], act_coef[9];
    int sh_ioff[3], act_ioff[3], sh_ooff[3], act_ooff[3];

    bit    ev[3];
    int    er[3], eg[3], eb[3];
    string et[3];

    function automatic int clampi(int x, int lo, int hi);
        return (x < lo) ? lo : (x > hi) ? hi : x;
    endfunction

    function automatic logic [31:0] pack2(int hi, int lo);
        return {16'(hi), 16'(lo)};
    endfunction

    function automatic logic [31:0] packoff(int o, int i);
        return {5'd0, 11'(o), 5'd0, 11'(i)};
    endfunction

    // reference model, one step per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            sh_ctrl = 0; act_ctrl = 0;
            for (int i = 0; i < 9; i++) begin sh_coef[i] = 0; act_coef[i] = 0; end
            for (int i = 0; i < 3; i++) begin
                sh_ioff[i] = 0; act_ioff[i] = 0; sh_ooff[i] = 0; act_ooff[i] = 0;
                ev[i] = 0; er[i] = 0; eg[i] = 0; eb[i] = 0; et[i] = "";
            end
        end else begin
            int c[9];
            int v[3];
            int o[3];
            for (int i = 0; i < 9; i++)
                c[i] = (act_ctrl & 2) ? act_coef[i] : ((act_ctrl & 1) ? p709[i] : p601[i]);
            for (int i = 2; i > 0; i--) begin
                ev[i] = ev[i-1]; er[i] = er[i-1]; eg[i] = eg[i-1]; eb[i] = eb[i-1]; et[i] = et[i-1];
            end
            if (in_is_yuv) begin
                v[0] = clampi(int'($signed(in_c0)) + act_ioff[0], -512, 512);
                v[1] = clampi(int'(in_c1) + act_ioff[1], 0, 1023);
                v[2] = clampi(int'($signed(in_c2)) + act_ioff[2], -512, 512);
                for (int r = 0; r < 3; r++) begin
                    int acc;
                    acc = c[3*r]*v[0] + c[3*r+1]*v[1] + c[3*r+2]*v[2];
                    o[r] = clampi(((acc + 2048) >>> 12) + act_ooff[r], 0, 1023);
                end
            end else begin
                o[0] = int'(in_c0[9:0]); o[1] = int'(in_c1); o[2] = int'(in_c2[9:0]);
            end
            ev[0] = in_valid; er[0] = o[0]; eg[0] = o[1]; eb[0] = o[2]; et[0] = cur_tag;
            if (frame_start) begin
                act_ctrl = sh_ctrl; act_coef = sh_coef; act_ioff = sh_ioff; act_ooff = sh_ooff;
            end
            if (cfg_we) begin
                int a;
                a = int'(cfg_addr);
                if (a == 0) sh_ctrl = int'(cfg_wdata[1:0]);
                else if (a >= 1 && a <= 4) begin
                    sh_coef[2*(a-1)]   = int'($signed(cfg_wdata[15:0]));
                    sh_coef[2*(a-1)+1] = int'($signed(cfg_wdata[31:16]));
                end else if (a == 5) sh_coef[8] = int'($signed(cfg_wdata[15:0]));
                else if (a >= 6 && a <= 8) begin
                    sh_ioff[a-6] = int'($signed(cfg_wdata[10:0]));
                    sh_ooff[a-6] = int'($signed(cfg_wdata[26:16]));
                end
            end
        end
    end

    // comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ev[2]) begin
                checks++;
                if (!out_valid || out_r != 10'(er[2]) || out_g != 10'(eg[2]) || out_b != 10'(eb[2])) begin
                    fails++;
                    $display("FAIL %s: got v=%0d rgb=(%0d,%0d,%0d) expected v=1 rgb=(%0d,%0d,%0d)",
                             et[2], out_valid, out_r, out_g, out_b, er[2], eg[2], eb[2]);
                end
            end else if (out_valid) begin
                checks++; fails++;
                $display("FAIL R8: got out_valid=1 expected out_valid=0");
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic pix(input bit yuv, input int c0, input int c1, input int c2, input string tag);
        @(negedge clk);
        in_valid = 1; in_is_yuv = yuv;
        in_c0 = 11'(c0); in_c1 = 10'(c1); in_c2 = 11'(c2);
        cur_tag = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0; cfg_we = 0; frame_start = 0;
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        in_valid = 0; cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic commit();
        idle(4);
        @(negedge clk);
        frame_start = 1;
        @(negedge clk);
        frame_start = 0;
        idle(1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_r !== 10'd0 || out_g !== 10'd0 || out_b !== 10'd0) begin
            fails++;
            $display("FAIL R2: got v=%0d rgb=(%0d,%0d,%0d) expected all 0", out_valid, out_r, out_g, out_b);
        end
        rst_n = 1;
        idle(2);

        // R2 / R1: default BT.601 preset, rounding and saturation
        pix(1, 0, 512, 0, "R2 default preset");
        pix(1, 100, 300, -200, "R1 mixed");
        pix(1, 512, 1023, 512, "R1 high saturation");
        pix(1, -512, 0, -512, "R1 low saturation");
        pix(1, -300, 700, 250, "R1 rounding");
        idle(2);
        pix(1, 7, 1, -3, "R8 after gap");
        idle(1);
        pix(1, 33, 64, 17, "R8 isolated");
        idle(4);

        // R9: shadow write without commit keeps the old matrix
        wr(0, 32'd1);
        pix(1, 200, 400, -100, "R9 not yet committed");
        pix(1, -150, 900, 300, "R9 not yet committed");
        commit();

        // R3: BT.709 preset
        pix(1, 200, 400, -100, "R3 bt709");
        pix(1, -150, 900, 300, "R3 bt709");
        pix(1, 512, 512, 512, "R3 bt709 sat");

        // R4: programmed coefficients, each distinct
        wr(1, pack2(2000, 100));
        wr(2, pack2(4096, -300));
        wr(3, pack2(800, -4096));
        wr(4, pack2(-50, 1234));
        wr(5, pack2(0, 3000));
        wr(0, 32'd2);
        commit();
        pix(1, 100, 200, 300, "R4 programmed");
        pix(1, -77, 611, 45, "R4 programmed");
        pix(1, 311, 13, -222, "R4 programmed");

        // R5 / R6: offsets and clamps
        wr(6, packoff(-20, 40));
        wr(7, packoff(5, 600));
        wr(8, packoff(100, -700));
        commit();
        pix(1, 0, 600, -100, "R6 clamp");
        pix(1, 480, 100, 300, "R6 clamp chroma high");
        pix(1, 10, 20, 30, "R5 offsets");

        // R7: RGB bypass interleaved with YCbCr
        pix(0, 11'h3FF, 1023, 11'h000, "R7 bypass");
        pix(1, 50, 500, -50, "R5 between bypass");
        pix(0, 11'h7AB, 321, 11'h455, "R7 bypass upper bit");
        pix(0, 0, 0, 1023, "R7 bypass");
        idle(4);

        // R9: writes to unmapped addresses change nothing; write at commit edge excluded
        wr(12, 32'hFFFF_FFFF);
        wr(15, 32'h1234_5678);
        idle(3);
        @(negedge clk);
        frame_start = 1; cfg_we = 1; cfg_addr = 4'd0; cfg_wdata = 32'd1;
        @(negedge clk);
        frame_start = 0; cfg_we = 0;
        idle(1);
        pix(1, 100, 200, 300, "R9 unmapped and same-edge write");
        pix(0, 5, 6, 7, "R7 bypass");
        commit();
        pix(1, 100, 200, 300, "R9 later commit");
        idle(6);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule